// File: doc/BRIEF.md
# Serial Link Startup Sequencer

This block walks a serial link from power-up or reset to normal operation. It steps through a fixed series of phases: clock-synthesizer settling, receiver initialization with byte alignment, an optional word-alignment phase, and finally run. Each phase lasts a set number of bit times, counted on a bit-time tick input. The settling phase also adds a fixed absolute delay, counted in sequencer clock cycles.

The synthesizer, clock recovery and aligner datapaths sit outside the block. The sequencer drives only their enable strobes, reports the current phase as a 2-bit code, and raises a registered ready flag once the link is running. A startup begins whenever the reference-clock-valid input becomes true, so the block starts correctly even if reset is never driven. Driving the active-low reset input, or losing the reference clock, restarts the sequence at any time. The reset input passes through a two-flop synchronizer. The word-alignment enable is expected to stay stable while a startup is in progress.

Top module: `link_start_seq`

## Requirements
- R1: When `rst_n` is sampled low at three consecutive rising edges, then from the third edge onward `phase` is 00, `ready`, `pll_en`, `rx_init` and `align_en` are 0, and all phase counters are cleared, so a later startup runs every phase at full length.
- R2: `phase` uses the code 00 = settling, 01 = receiver init, 10 = word align, 11 = run. It only moves 00 to 01, then 01 to 10 or 11, then 10 to 11. Once at 11 it stays there until a reset or a loss of the reference clock.
- R3: The settling phase 00 ends only after `PLL_BITS` bit ticks, followed by `SETTLE_CYC` further clock cycles. Ticks arriving during those further cycles have no effect on when the phase ends.
- R4: The receiver-init phase 01 lasts `RXI_BITS_NOWA` bit ticks when `wa_en` is 0 and `RXI_BITS_WA` bit ticks when `wa_en` is 1. Clock edges without a tick do not advance it.
- R5: Phase 10 follows 01 only when `wa_en` is 1, and it lasts `WA_BITS` bit ticks. When `wa_en` is 0, phase 01 goes straight to 11.
- R6: When `refclk_ok` is sampled low at a rising edge, then after that edge `phase` is 00, `pll_en` is 0 and the counters are cleared. A full startup follows once `refclk_ok` returns high, whether or not reset was ever asserted.
- R7: `ready` is 1 exactly when `phase` is 11. It is a register output that changes on the same edge as `phase`.
- R8: `rx_init` is 1 exactly in phase 01 and `align_en` is 1 exactly in phase 10. `pll_en` is 1 in phases 01, 10 and 11, and is 0 while reset or reference-clock loss holds the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (reference-clock domain) |
| rst_n | input | 1 | Active-low restart request, synchronized inside |
| wa_en | input | 1 | Word-alignment enable; selects init length and whether phase 10 runs |
| refclk_ok | input | 1 | Reference clock present and valid |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| phase | output | 2 | Current phase code |
| pll_en | output | 1 | Enable toward the clock synthesizer |
| rx_init | output | 1 | Receiver initialization / byte alignment strobe |
| align_en | output | 1 | Word aligner enable |
| ready | output | 1 | Link in run state |

## Verification
The hardest cases to reach are interruptions that land partway through a phase, especially while the settling phase is in its absolute-delay part, where bit ticks must be ignored. Reaching them also requires that a restart fully clears the counters. The stimulus runs a random number of cycles at a random tick density, then drops `refclk_ok` or pulses `rst_n`. The bench models which ticks count, including those absorbed during the settle delay and the synchronizer latency. It then checks every later phase length against the requirement values.

// File: rtl/lss_pkg.sv
// Shared types for the link startup sequencer.
// Assumes: the phase code values are visible at the block's ports and must not change.
package lss_pkg;

    typedef enum logic [1:0] {
        PH_PLL = 2'b00,
        PH_RXI = 2'b01,
        PH_WAL = 2'b10,
        PH_RUN = 2'b11
    } phase_e;

endpackage

// File: rtl/lss_rst_sync.sv
// Two-flop synchronizer for the active-low restart request.
// Assumes: rst_n may change at any time relative to clk; the output is usable as a synchronous reset.
module lss_rst_sync (
    input  logic clk,
    input  logic rst_n,
    output logic srst_n
);

    logic meta_q;
    logic sync_q;

    // Shift the raw request through two flops.
    always_ff @(posedge clk) begin
        meta_q <= rst_n;
        sync_q <= meta_q;
    end

    assign srst_n = sync_q;

endmodule

// File: rtl/lss_tick_counter.sv
// Saturating up-counter with a run-time limit.
// It reports the increment that reaches the limit (last) and whether the limit has been reached (full).
// Assumes: clr has priority, and limit only changes on cycles where clr is asserted.
module lss_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         last,
    output logic         full
);

    logic [W-1:0] cnt_q;

    assign full = (cnt_q == limit);
    assign last = en && !full && (cnt_q == limit - 1'b1);

    // Clear on request, otherwise count enabled events up to the limit.
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (en && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/link_start_seq.sv
// Link startup sequencer. It steps settling -> receiver init -> (word align) -> run.
// Phase lengths are counted in bit ticks; settling also waits an absolute delay counted in clk cycles.
// Assumes: clk runs from the reference clock; bit_tick is a single-cycle pulse; wa_en is stable
// during a startup; SETTLE_CYC >= 1 and every bit count >= 1.
module link_start_seq #(
    parameter int PLL_BITS      = 20480,
    parameter int SETTLE_CYC    = 1250,
    parameter int RXI_BITS_NOWA = 300,
    parameter int RXI_BITS_WA   = 460,
    parameter int WA_BITS       = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wa_en,
    input  logic       refclk_ok,
    input  logic       bit_tick,
    output logic [1:0] phase,
    output logic       pll_en,
    output logic       rx_init,
    output logic       align_en,
    output logic       ready
);
    import lss_pkg::*;

    localparam int MAX_A = (PLL_BITS > RXI_BITS_NOWA) ? PLL_BITS : RXI_BITS_NOWA;
    localparam int MAX_B = (RXI_BITS_WA > WA_BITS) ? RXI_BITS_WA : WA_BITS;
    localparam int MAX_BITS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int BW = $clog2(MAX_BITS + 1);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic          srst_n;
    phase_e        state_q;
    phase_e        state_d;
    logic          seq_clr;
    logic [BW-1:0] bit_limit;
    logic          bit_last;
    logic          bit_full;
    logic          settle_en;
    logic          settle_last;
    logic          settle_full;

    lss_rst_sync u_rst_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_n (srst_n)
    );

    // Bit-time length of the current phase.
    always_comb begin
        unique case (state_q)
            PH_PLL:  bit_limit = BW'(PLL_BITS);
            PH_RXI:  bit_limit = wa_en ? BW'(RXI_BITS_WA) : BW'(RXI_BITS_NOWA);
            PH_WAL:  bit_limit = BW'(WA_BITS);
            default: bit_limit = '0;
        endcase
    end

    lss_tick_counter #(.W(BW)) u_bit_cnt (
        .clk   (clk),
        .clr   (seq_clr),
        .en    (bit_tick),
        .limit (bit_limit),
        .last  (bit_last),
        .full  (bit_full)
    );

    assign settle_en = (state_q == PH_PLL) && bit_full;

    lss_tick_counter #(.W(SW)) u_settle_cnt (
        .clk   (clk),
        .clr   (seq_clr),
        .en    (settle_en),
        .limit (SW'(SETTLE_CYC)),
        .last  (settle_last),
        .full  (settle_full)
    );

    // Next-phase selection; restart conditions override normal progress.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_PLL:  if (settle_last) state_d = PH_RXI;
            PH_RXI:  if (bit_last) state_d = wa_en ? PH_WAL : PH_RUN;
            PH_WAL:  if (bit_last) state_d = PH_RUN;
            default: state_d = PH_RUN;
        endcase
        if (!srst_n || !refclk_ok) begin
            state_d = PH_PLL;
        end
    end

    // Counters restart on every phase change and while held.
    assign seq_clr = !srst_n || !refclk_ok || (state_d != state_q);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state_q <= PH_PLL;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobes and ready, aligned with the phase register.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            pll_en   <= 1'b0;
            rx_init  <= 1'b0;
            align_en <= 1'b0;
            ready    <= 1'b0;
        end else begin
            pll_en   <= refclk_ok;
            rx_init  <= (state_d == PH_RXI);
            align_en <= (state_d == PH_WAL);
            ready    <= (state_d == PH_RUN);
        end
    end

    assign phase = state_q;

    // R2: settling may only continue or move on to receiver init
    a_r2_from_settle: assert property (@(posedge clk) disable iff (!srst_n)
        (state_q == PH_PLL) |=> (state_q == PH_PLL || state_q == PH_RXI));

    // R3: settling cannot end before the bit count is complete
    a_r3_no_early_exit: assert property (@(posedge clk) disable iff (!srst_n)
        (state_q == PH_PLL && !bit_full) |=> (state_q == PH_PLL));

    // R5: with word alignment off, phase 10 is never entered from init
    a_r5_skip_align: assert property (@(posedge clk) disable iff (!srst_n)
        (state_q == PH_RXI && !wa_en) |=> (state_q != PH_WAL));

    // R6: reference-clock loss returns to settling with the synthesizer disabled
    a_r6_refclk_loss: assert property (@(posedge clk) disable iff (!srst_n)
        !refclk_ok |=> (state_q == PH_PLL && !pll_en));

    // R7: ready tracks the run phase
    a_r7_ready_run: assert property (@(posedge clk) disable iff (!srst_n)
        ready == (state_q == PH_RUN));

    // R8: at most one of the phase strobes and ready is active
    a_r8_onehot: assert property (@(posedge clk) disable iff (!srst_n)
        $onehot0({rx_init, align_en, ready}));

endmodule

// File: tb/link_start_seq_bench.sv
// Bench for link_start_seq: random tick density, random restarts, directed corner cases.
module link_start_seq_bench;

    localparam int PB = 40;
    localparam int SC = 25;
    localparam int RN = 12;
    localparam int RW = 20;
    localparam int WB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       wa_en = 1'b0;
    logic       refclk_ok = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] phase;
    logic       pll_en;
    logic       rx_init;
    logic       align_en;
    logic       ready;

    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;
    int         tk[4];
    int         settle = 0;
    logic [1:0] prev_ph = 2'd0;
    logic [1:0] ph_obs = 2'd0;
    bit         restart_ok = 1'b1;

    always #10 clk = ~clk;

    link_start_seq #(
        .PLL_BITS(PB), .SETTLE_CYC(SC), .RXI_BITS_NOWA(RN),
        .RXI_BITS_WA(RW), .WA_BITS(WB)
    ) u_link_start_seq (
        .clk(clk), .rst_n(rst_n), .wa_en(wa_en), .refclk_ok(refclk_ok),
        .bit_tick(bit_tick), .phase(phase), .pll_en(pll_en),
        .rx_init(rx_init), .align_en(align_en), .ready(ready)
    );

    function automatic int exp_rxi(bit wa);
        return wa ? RW : RN;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL R2: watchdog, actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // One cycle: observe at negedge, check, then drive the tick for the next edge.
    task automatic do_cycle(int pct, bit quiet);
        bit t;
        @(negedge clk);
        ph_obs = phase;
        chk(ready == (ph_obs == 2'd3), "R7", ready, ph_obs == 2'd3);
        chk(rx_init == (ph_obs == 2'd1), "R8", rx_init, ph_obs == 2'd1);
        chk(align_en == (ph_obs == 2'd2), "R8", align_en, ph_obs == 2'd2);
        if (ph_obs != 2'd0) chk(pll_en == 1'b1, "R8", pll_en, 1);
        if (ph_obs != prev_ph) begin
            if (ph_obs == 2'd0) begin
                chk(restart_ok, "R2", ph_obs, prev_ph);
            end else if (prev_ph == 2'd0) begin
                chk(ph_obs == 2'd1, "R2", ph_obs, 1);
                chk(tk[0] == PB, "R3", tk[0], PB);
                chk(settle == SC, "R3", settle, SC);
            end else if (prev_ph == 2'd1) begin
                chk(ph_obs == (wa_en ? 2'd2 : 2'd3), "R5", ph_obs, wa_en ? 2 : 3);
                chk(tk[1] == exp_rxi(wa_en), "R4", tk[1], exp_rxi(wa_en));
            end else if (prev_ph == 2'd2) begin
                chk(ph_obs == 2'd3, "R2", ph_obs, 3);
                chk(tk[2] == WB, "R5", tk[2], WB);
            end else begin
                chk(1'b0, "R2", ph_obs, prev_ph);
            end
            tk[ph_obs] = 0;
            if (ph_obs == 2'd0) settle = 0;
            prev_ph = ph_obs;
        end
        t = quiet ? 1'b0 : ($urandom_range(99) < pct);
        if (quiet) begin
            for (int i = 0; i < 4; i++) tk[i] = 0;
            settle = 0;
        end else if (ph_obs == 2'd0) begin
            if (tk[0] < PB) tk[0] += int'(t);
            else settle++;
        end else if (ph_obs != 2'd3) begin
            tk[ph_obs] += int'(t);
        end
        bit_tick = t;
    endtask

    task automatic run_to_ready(int pct);
        for (int i = 0; i < 3000 && ph_obs != 2'd3; i++) do_cycle(pct, 1'b0);
        chk(ph_obs == 2'd3, "R2", ph_obs, 3);
        repeat (20) do_cycle(pct, 1'b0);
        chk(ph_obs == 2'd3 && ready, "R7", ph_obs, 3);
    endtask

    task automatic drop_refclk(bit wa);
        restart_ok = 1'b1;
        refclk_ok = 1'b0;
        do_cycle(0, 1'b1);
        chk(ph_obs == 2'd0, "R6", ph_obs, 0);
        chk(pll_en == 1'b0, "R6", pll_en, 0);
        chk(ready == 1'b0, "R6", ready, 0);
        wa_en = wa;
        repeat (3) do_cycle(0, 1'b1);
        refclk_ok = 1'b1;
        do_cycle(0, 1'b1);
        restart_ok = 1'b0;
    endtask

    task automatic pulse_reset(bit wa);
        restart_ok = 1'b1;
        rst_n = 1'b0;
        repeat (3) do_cycle(0, 1'b0);
        do_cycle(0, 1'b1);
        chk(ph_obs == 2'd0, "R1", ph_obs, 0);
        chk({ready, pll_en, rx_init, align_en} == 4'b0, "R1",
            {ready, pll_en, rx_init, align_en}, 0);
        wa_en = wa;
        repeat (2) do_cycle(0, 1'b1);
        rst_n = 1'b1;
        repeat (3) do_cycle(0, 1'b1);
        restart_ok = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7151));
        for (int i = 0; i < 4; i++) tk[i] = 0;
        // R6: start with reset never asserted, reference clock absent.
        repeat (6) do_cycle(0, 1'b1);
        chk(ph_obs == 2'd0, "R6", ph_obs, 0);
        chk(pll_en == 1'b0, "R8", pll_en, 0);
        chk(ready == 1'b0, "R7", ready, 0);
        refclk_ok = 1'b1;
        do_cycle(0, 1'b1);
        restart_ok = 1'b0;
        run_to_ready(100);
        // R1: directed reset, then a startup with word alignment at full tick rate.
        pulse_reset(1'b1);
        run_to_ready(100);
        // Random full startups with sparse ticks (R4: cycles without ticks do not count).
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) pulse_reset(1'($urandom_range(1)));
            else drop_refclk(1'($urandom_range(1)));
            run_to_ready(20 + $urandom_range(80));
        end
        // Interruptions partway through a random phase, including the settle delay.
        for (int i = 0; i < 8; i++) begin
            int pct;
            pct = 30 + $urandom_range(70);
            drop_refclk(1'($urandom_range(1)));
            repeat (1 + $urandom_range(140)) do_cycle(pct, 1'b0);
            if (i % 2 == 0) drop_refclk(1'($urandom_range(1)));
            else pulse_reset(1'($urandom_range(1)));
            run_to_ready(pct);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule